// File: doc/BRIEF.md
# Fixed-Address Idle-Mode DMA Channel

This block is one DMA channel that shuttles a single byte or word per request between two addresses that never move. The first address is a full memory address held in a register. The second is an I/O address. It is built from a narrower register, and every bit above that register is forced to one. A direction bit decides which address is read and which one is written. A down-counter sets the number of transfers in a run. When that counter reaches zero, the channel raises its interrupt and refuses further requests until software loads a new count.

Each transfer is two phases on a simple bus master port: a read from the source, then a write of the captured data to the destination. Each phase completes on the cycle in which the bus returns ready. The channel accepts a request only when both the repeat-enable bit and the end-interrupt-enable bit are set. One request that arrives during a transfer is held and serviced afterwards. Register writes are accepted only while no transfer is in flight.

Top module: `idle_dma_chan`

## Requirements
- R1: A request is serviced only when control bit 0 (repeat enable) and control bit 1 (end-interrupt enable) are both 1. Otherwise the request causes no bus activity.
- R2: Each serviced request produces exactly one bus read from the source, followed by exactly one bus write to the destination. The read and write strobes are never high together.
- R3: The memory address (register select 0) and the I/O address stay the same across transfers. With control bit 2 (direction) at 0, the memory address is read and the I/O address is written. With it at 1, the roles are swapped.
- R4: The I/O address on the bus is the 16-bit I/O register (register select 1), with bits 23 to 16 all set to one.
- R5: Register select 2 loads the transfer count. Every completed write decrements it. After the write that brings it to zero, irq_o goes high on the next cycle. Later requests cause no bus activity until a new nonzero count is written.
- R6: With control bit 3 (word size) at 1, a request whose memory address or I/O address is odd causes no bus activity and sets err_o.
- R7: While bus_rdy_i is low during a phase, the strobe and the address stay unchanged.
- R8: Any number of requests that arrive during one transfer are kept as one pending request. That request is serviced when the transfer finishes.
- R9: Register writes made while a transfer is in flight have no effect.
- R10: irq_o and err_o stay high until a control write (register select 3) with bit 5 set clears both.
- R11: With control bit 3 at 0, bus_word_o is low and the written data is the low byte of the read data, zero-extended. With control bit 3 at 1, bus_word_o is high and the full 16-bit word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 memory address, 1 I/O address, 2 count, 3 control |
| reg_wdata_i | input | 24 | Register write data |
| req_i | input | 1 | Transfer request, one per cycle high |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_word_o | output | 1 | Access is a 16-bit word |
| bus_addr_o | output | 24 | Bus address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data |
| bus_rdy_i | input | 1 | Current phase completes this cycle |
| irq_o | output | 1 | End-of-run interrupt |
| err_o | output | 1 | Misaligned word request seen |

## Verification
A wrong count value shows up as an interrupt that arrives one transfer too early or too late. It also shows up as an extra bus pair after the end of the run, which can be seen within the same transfer. A mux that picks the wrong address or direction shows on the first read strobe of a request. A lost or duplicated pending request changes the number of bus pairs seen after a burst of requests. This difference can be seen one transfer time later. A register write that leaks in while a transfer is in flight appears as a changed address on the next request.

// File: rtl/idle_dma_pkg.sv
package idle_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dma_state_e;

  localparam logic [1:0] SEL_MEM  = 2'd0;
  localparam logic [1:0] SEL_IO   = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam int unsigned CB_RPT  = 0;
  localparam int unsigned CB_TIE  = 1;
  localparam int unsigned CB_DIR  = 2;
  localparam int unsigned CB_WORD = 3;
  localparam int unsigned CB_CLR  = 5;

  typedef struct packed {
    logic word;
    logic dir;
    logic tie;
    logic rpt;
  } dma_ctrl_t;
endpackage

// File: rtl/idle_dma_regs.sv
module idle_dma_regs
  import idle_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IO_W   = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              err_set_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [IO_W-1:0]   ioar_o,
  output dma_ctrl_t         ctrl_o,
  output logic              armed_o,
  output logic              end_o,
  output logic              err_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             wr_ok;

  assign wr_ok = we_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_o   <= '0;
      ioar_o  <= '0;
      cnt_q   <= '0;
      ctrl_o  <= '0;
      armed_o <= 1'b0;
      end_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      if (wr_ok) begin
        unique case (sel_i)
          SEL_MEM: mar_o  <= wdata_i;
          SEL_IO:  ioar_o <= wdata_i[IO_W-1:0];
          SEL_CNT: begin
            cnt_q   <= wdata_i[CNT_W-1:0];
            armed_o <= |wdata_i[CNT_W-1:0];
          end
          default: begin
            ctrl_o.rpt  <= wdata_i[CB_RPT];
            ctrl_o.tie  <= wdata_i[CB_TIE];
            ctrl_o.dir  <= wdata_i[CB_DIR];
            ctrl_o.word <= wdata_i[CB_WORD];
            if (wdata_i[CB_CLR]) begin
              end_o <= 1'b0;
              err_o <= 1'b0;
            end
          end
        endcase
      end
      if (done_i) begin
        cnt_q <= cnt_q - CNT_ONE;
        if (cnt_q == CNT_ONE) begin
          end_o   <= 1'b1;
          armed_o <= 1'b0;
        end
      end
      if (err_set_i) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/idle_dma_seq.sv
module idle_dma_seq
  import idle_dma_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              active_i,
  input  logic              misalign_i,
  input  logic              word_i,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_set_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned BYTE_W = 8;

  dma_state_e state_q, state_d;
  logic       pend_q;
  logic       go;

  assign go        = req_i | pend_q;
  assign rd_o      = (state_q == ST_RD);
  assign wr_o      = (state_q == ST_WR);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = wr_o & rdy_i;
  assign err_set_o = (state_q == ST_IDLE) & go & active_i & misalign_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go && active_i && !misalign_i) state_d = ST_RD;
      ST_RD:   if (rdy_i) state_d = ST_WR;
      default: if (rdy_i) state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      data_o  <= '0;
    end else begin
      state_q <= state_d;
      // idle consumes or drops the pending request
      pend_q  <= busy_o & (pend_q | req_i);
      if (rd_o && rdy_i)
        data_o <= word_i ? rdata_i : {{(DATA_W-BYTE_W){1'b0}}, rdata_i[BYTE_W-1:0]};
    end
  end
endmodule

// File: rtl/idle_dma_chan.sv
module idle_dma_chan
  import idle_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IO_W   = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              req_i,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic              bus_word_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_rdy_i,
  output logic              irq_o,
  output logic              err_o
);
  localparam int unsigned HI_W = ADDR_W - IO_W;

  logic [ADDR_W-1:0] mar_q, io_addr, src_addr, dst_addr;
  logic [IO_W-1:0]   ioar_q;
  dma_ctrl_t         ctrl;
  logic              armed, end_q, busy, done, err_set, active, misalign;

  idle_dma_regs #(.ADDR_W(ADDR_W), .IO_W(IO_W), .CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .sel_i    (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .busy_i   (busy),
    .done_i   (done),
    .err_set_i(err_set),
    .mar_o    (mar_q),
    .ioar_o   (ioar_q),
    .ctrl_o   (ctrl),
    .armed_o  (armed),
    .end_o    (end_q),
    .err_o    (err_o)
  );

  assign io_addr  = {{HI_W{1'b1}}, ioar_q};
  assign src_addr = ctrl.dir ? io_addr : mar_q;
  assign dst_addr = ctrl.dir ? mar_q : io_addr;
  assign active   = ctrl.rpt & ctrl.tie & armed;
  assign misalign = ctrl.word & (mar_q[0] | ioar_q[0]);

  idle_dma_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .active_i  (active),
    .misalign_i(misalign),
    .word_i    (ctrl.word),
    .rdy_i     (bus_rdy_i),
    .rdata_i   (bus_rdata_i),
    .rd_o      (bus_rd_o),
    .wr_o      (bus_wr_o),
    .busy_o    (busy),
    .done_o    (done),
    .err_set_o (err_set),
    .data_o    (bus_wdata_o)
  );

  assign bus_addr_o = bus_rd_o ? src_addr : (bus_wr_o ? dst_addr : '0);
  assign bus_word_o = busy & ctrl.word;
  assign irq_o      = end_q;
endmodule

// File: rtl/idle_dma_chan_chk.sv
module idle_dma_chan_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IO_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [ADDR_W-1:0] reg_wdata_i,
  input logic              bus_rd_o,
  input logic              bus_wr_o,
  input logic              bus_word_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_rdy_i,
  input logic              irq_o,
  input logic [ADDR_W-1:0] mar_i
);
  logic any_ph, clr_wr;
  assign any_ph = bus_rd_o | bus_wr_o;
  assign clr_wr = reg_we_i && reg_addr_i == 2'd3 && reg_wdata_i[5];

  assert_one_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));
  assert_rd_then_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o && bus_rdy_i |=> bus_wr_o);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ph && !bus_rdy_i |=> $stable(bus_addr_o) && $stable(bus_rd_o) && $stable(bus_wr_o));
  assert_io_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ph |-> (bus_addr_o == mar_i) || (&bus_addr_o[ADDR_W-1:IO_W]));
  assert_even_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ph && bus_word_o |-> !bus_addr_o[0]);
  assert_irq_after_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(bus_wr_o && bus_rdy_i));
  assert_irq_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_wr |=> irq_o);
endmodule

bind idle_dma_chan idle_dma_chan_chk #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .bus_rd_o   (bus_rd_o),
  .bus_wr_o   (bus_wr_o),
  .bus_word_o (bus_word_o),
  .bus_addr_o (bus_addr_o),
  .bus_rdy_i  (bus_rdy_i),
  .irq_o      (irq_o),
  .mar_i      (mar_q)
);

// File: tb/idle_dma_chan_test.sv
`timescale 1ns/1ps
module idle_dma_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic        req = 1'b0;
  logic        bus_rd, bus_wr, bus_word, irq, err;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_rdy = 1'b0;

  always #4 clk = ~clk;

  idle_dma_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .req_i(req), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr),
    .bus_word_o(bus_word), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_rdy_i(bus_rdy), .irq_o(irq), .err_o(err)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // transaction log filled by the bus model
  logic        lg_wr   [0:1023];
  logic [23:0] lg_addr [0:1023];
  logic [15:0] lg_data [0:1023];
  logic        lg_word [0:1023];
  int          nlog = 0;
  int          fixed_stall = -1;
  int          wcnt = 0;
  int          tgt = 0;

  function automatic logic [15:0] mem_val(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  always @(negedge clk) begin
    if (rst_n && (bus_rd || bus_wr)) begin
      if (wcnt >= tgt) begin
        bus_rdy   = 1'b1;
        bus_rdata = bus_rd ? mem_val(bus_addr) : 16'h0;
        lg_wr[nlog]   = bus_wr;
        lg_addr[nlog] = bus_addr;
        lg_data[nlog] = bus_wdata;
        lg_word[nlog] = bus_word;
        nlog++;
        wcnt = 0;
        tgt  = (fixed_stall >= 0) ? fixed_stall : int'($urandom % 3);
      end else begin
        bus_rdy = 1'b0;
        wcnt++;
      end
    end else begin
      bus_rdy = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) begin
      pulse_req();
      settle();
    end
  endtask

  function automatic logic [23:0] io_full(input logic [15:0] io);
    return {8'hFF, io};
  endfunction

  task automatic chk_pairs(input string tag, input int base, input int n,
                           input logic [23:0] src, input logic [23:0] dst, input logic word);
    logic [15:0] exp_d;
    exp_d = word ? mem_val(src) : {8'h00, mem_val(src)[7:0]};
    chk({tag, " count"}, 64'(nlog), 64'(base + 2 * n));
    for (int i = 0; i < n; i++) begin
      chk({tag, " rd"}, {lg_wr[base+2*i], lg_word[base+2*i], lg_addr[base+2*i]},
          {1'b0, word, src});
      chk({tag, " wr"}, {lg_wr[base+2*i+1], lg_word[base+2*i+1], lg_addr[base+2*i+1], lg_data[base+2*i+1]},
          {1'b1, word, dst, exp_d});
    end
  endtask

  // control word: bit0 repeat, bit1 irq enable, bit2 dir, bit3 word, bit5 clear
  function automatic logic [23:0] ctl(input logic dir, input logic word, input logic clr);
    return {18'h0, clr, 1'b0, word, dir, 2'b11};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    chk("reset R2 strobes", {62'h0, bus_rd, bus_wr}, 64'h0);
    chk("reset R10 flags", {62'h0, irq, err}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: enables incomplete
    wr_reg(2'd0, 24'h123456); wr_reg(2'd1, 24'h008000); wr_reg(2'd2, 24'd3);
    wr_reg(2'd3, 24'h000001);
    run_n(1);
    wr_reg(2'd3, 24'h000002);
    run_n(1);
    chk("R1 no bus activity", 64'(nlog), 64'd0);

    // R2 R3 R4 R5 word dir=0
    wr_reg(2'd3, ctl(1'b0, 1'b1, 1'b1));
    run_n(2);
    chk("R5 no irq before last", {63'h0, irq}, 64'h0);
    run_n(1);
    chk_pairs("R3 R4 dir0 word", 0, 3, 24'h123456, io_full(16'h8000), 1'b1);
    chk("R5 irq at end", {63'h0, irq}, 64'h1);
    run_n(1);
    chk("R5 ignored after end", 64'(nlog), 64'd6);
    chk("R10 irq held", {63'h0, irq}, 64'h1);
    wr_reg(2'd3, ctl(1'b0, 1'b1, 1'b1));
    chk("R10 irq cleared", {63'h0, irq}, 64'h0);

    // R3 dir=1 R11 byte with odd addresses
    wr_reg(2'd0, 24'h0ABCD1); wr_reg(2'd1, 24'h00F013);
    wr_reg(2'd3, ctl(1'b1, 1'b0, 1'b0)); wr_reg(2'd2, 24'd2);
    base = nlog;
    run_n(2);
    chk_pairs("R11 R3 dir1 byte", base, 2, io_full(16'hF013), 24'h0ABCD1, 1'b0);
    chk("R11 irq", {63'h0, irq}, 64'h1);
    wr_reg(2'd3, ctl(1'b0, 1'b1, 1'b1));

    // R6 misaligned word
    wr_reg(2'd0, 24'h000101); wr_reg(2'd1, 24'h000200); wr_reg(2'd2, 24'd4);
    base = nlog;
    run_n(1);
    chk("R6 no bus activity", 64'(nlog), 64'(base));
    chk("R6 err set", {63'h0, err}, 64'h1);
    wr_reg(2'd3, ctl(1'b0, 1'b1, 1'b1));
    chk("R10 err cleared", {63'h0, err}, 64'h0);

    // R7 stall, R9 writes during transfer ignored
    wr_reg(2'd0, 24'h000A00); wr_reg(2'd1, 24'h000B00); wr_reg(2'd2, 24'd5);
    fixed_stall = 6; tgt = 6;
    base = nlog;
    pulse_req();
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 24'h000C00;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R7 read held while not ready", {62'h0, bus_rd, bus_wr}, 64'h2);
    chk("R7 no handshake yet", 64'(nlog), 64'(base));
    settle();
    fixed_stall = -1;
    run_n(1);
    chk_pairs("R9 mem addr unchanged", base, 2, 24'h000A00, io_full(16'h0B00), 1'b1);

    // R8: burst of requests during one transfer
    fixed_stall = 4; tgt = 4;
    base = nlog;
    pulse_req();
    pulse_req();
    pulse_req();
    settle(); settle();
    fixed_stall = -1;
    chk_pairs("R8 single pending", base, 2, 24'h000A00, io_full(16'h0B00), 1'b1);

    // random runs
    for (int it = 0; it < 20; it++) begin
      logic [23:0] m;
      logic [15:0] io;
      logic dir, word;
      int n;
      m = 24'($urandom); io = 16'($urandom);
      dir = 1'($urandom); word = 1'($urandom);
      n = 1 + int'($urandom % 3);
      if (word) begin m[0] = 1'b0; io[0] = 1'b0; end
      wr_reg(2'd0, m); wr_reg(2'd1, {8'h00, io});
      wr_reg(2'd3, ctl(dir, word, 1'b1)); wr_reg(2'd2, 24'(n));
      base = nlog;
      run_n(n);
      chk_pairs("R3 R5 random", base, n,
                dir ? io_full(io) : m, dir ? m : io_full(io), word);
      chk("R5 random irq", {63'h0, irq}, 64'h1);
      run_n(1);
      chk("R5 random ignored", 64'(nlog), 64'(base + 2 * n));
    end

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule